// File: doc/BRIEF.md
# Serial Configuration Bitstream Readout Controller

This block holds a small array of configuration bits and streams them, one bit per serial clock period, to the serial data input of a programmable logic device. The array is loaded through a synchronous write port, one word (one row) at a time. An active-high output-enable input acts as the readout reset. While it is low the read address returns to the first bit, the data output is released and the serial clock stops. An active-low select then starts or pauses the readout.

The read address is a bit counter inside a row plus a row counter. The bit counter's terminal count steps the row. A device that sees its select low while output-enable is low becomes the clock source. It divides the system clock to produce the serial clock and moves to the next bit on each falling edge of that clock, so the receiver can sample on the rising edge. A device that sees its select high at that time becomes a follower. It produces no clock and advances on the falling edges of an external serial clock.

After the last bit has been sent, the device lowers its cascade output and releases the data line, so the next device in a chain can take over. This state holds until the next output-enable reset. The external data line is modelled as a data bit plus a drive enable.

Top module: `cfg_bit_streamer`

## Requirements
- R1: After power-up reset, `casc_n` is 1, `data_oe` is 0 and `dclk_o` is 0.
- R2: While `oe` is 0, `data_oe` is 0, `dclk_o` is 0 and `casc_n` is 1, whatever `sel_n` is. When `oe` returns to 1, readout restarts at bit 0.
- R3: With `oe` at 1 and `sel_n` at 1, `data_oe` is 0, no serial clock edge is produced and the read address holds. When `sel_n` falls again, readout resumes at the held bit.
- R4: With `oe` at 1, `sel_n` at 0 and the data not exhausted, `data_oe` is 1 and `data_o` shows the stored bit at the current address.
- R5: Bit address k maps to row k / COLS, bit position k mod COLS of that row (bit 0 is the least significant bit). Readout starts at row 0, bit 0.
- R6: On a clock-source device, `dclk_o` starts low and has a period of 2*HALF system clocks. `data_o` changes only right after a falling edge of `dclk_o` and is steady while `dclk_o` is high.
- R7: On the falling edge that ends the last bit (row ROWS-1, bit COLS-1), `casc_n` goes to 0, `data_oe` goes to 0 and `dclk_o` stays at 0. Toggling `sel_n` does not change this. Only a low on `oe` clears it.
- R8: A device whose `sel_n` was 1 while `oe` was 0 keeps `dclk_o` at 0. It advances one bit per falling edge of `ext_dclk`.
- R9: A write with `wr_en` at 1 stores `wr_word` as row `wr_row`. Those bits are what the next readout of that row streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also feeds the serial clock divider |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | $clog2(ROWS) | Row index written |
| wr_word | input | COLS | Row contents written |
| sel_n | input | 1 | Active-low select |
| oe | input | 1 | Output enable; a low level resets the readout |
| ext_dclk | input | 1 | Serial clock from an upstream device, used by a follower |
| dclk_o | output | 1 | Generated serial clock |
| data_o | output | 1 | Serial data bit |
| data_oe | output | 1 | Drive enable for the data line |
| casc_n | output | 1 | Active-low cascade output, low once the data is exhausted |

## Verification
The hardest situations to reach are a pause through `sel_n` in the middle of a serial clock high phase, and the follower role. A pause at that point must keep the current bit rather than skip it. The follower role exists only when `sel_n` is high during the `oe` reset. For the pause, the bench raises `sel_n` on the cycle right after it sees a rising serial clock edge. It then checks that the resumed stream repeats that same bit. For the follower role, the bench holds `sel_n` high through the reset and then drives `ext_dclk` by hand. It checks each advance, and it checks that `dclk_o` never moves.

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int HALF = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(ROWS)-1:0] wr_row,
  input  logic [COLS-1:0]         wr_word,
  input  logic                    sel_n,
  input  logic                    oe,
  input  logic                    ext_dclk,
  output logic                    dclk_o,
  output logic                    data_o,
  output logic                    data_oe,
  output logic                    casc_n
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int DW = $clog2(HALF + 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(COLS - 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

  logic [COLS-1:0] mem [ROWS];
  logic [RW-1:0]   row_q;
  logic [CW-1:0]   bit_q;
  logic [DW-1:0]   div_q;
  logic            done_q, lead_q, dclk_q, e1_q, e2_q;

  logic run, tick, adv, bit_tc, last;
  assign run    = oe & ~sel_n & ~done_q;
  assign tick   = run & lead_q & (div_q == DIV_LAST);
  assign adv    = (tick & dclk_q) | (run & ~lead_q & e2_q & ~e1_q);
  assign bit_tc = (bit_q == BIT_LAST);
  assign last   = bit_tc & (row_q == ROW_LAST);

  always_ff @(posedge clk)
    if (wr_en) mem[wr_row] <= wr_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      e1_q <= 1'b0;
      e2_q <= 1'b0;
    end else begin
      e1_q <= ext_dclk;
      e2_q <= e1_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      row_q  <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      done_q <= 1'b0;
      lead_q <= 1'b0;
      dclk_q <= 1'b0;
    end else if (!oe) begin
      row_q  <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      done_q <= 1'b0;
      dclk_q <= 1'b0;
      lead_q <= ~sel_n;
    end else begin
      if (!run) begin
        div_q  <= '0;
        dclk_q <= 1'b0;
      end else if (lead_q) begin
        if (tick) begin
          div_q  <= '0;
          dclk_q <= ~dclk_q;
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
      if (adv) begin
        if (last) done_q <= 1'b1;
        else if (bit_tc) begin
          bit_q <= '0;
          row_q <= row_q + RW'(1);
        end else begin
          bit_q <= bit_q + CW'(1);
        end
      end
    end

  assign data_oe = run;
  assign data_o  = run & mem[row_q][bit_q];
  assign casc_n  = ~done_q;
  assign dclk_o  = dclk_q;

  a_r2_oe_resets: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |=> (casc_n && !dclk_o));

  a_r3_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && sel_n) |=> (!oe || ($stable(row_q) && $stable(bit_q))));

  a_r6_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dclk_o) && dclk_o && $past(data_oe) && data_oe && !$past(wr_en))
      |-> (data_o == $past(data_o)));

  a_r7_exhausted_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !casc_n) |=> !casc_n);

  a_r8_follower_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_q |-> !dclk_o);
endmodule

// File: tb/test_cfg_bit_streamer.sv
module test_cfg_bit_streamer;
  localparam int ROWS = 16;
  localparam int COLS = 8;
  localparam int HALF = 2;
  localparam int NBITS = ROWS * COLS;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sel_n = 1'b1, oe = 1'b1, ext_dclk = 1'b0;
  logic [3:0] wr_row = '0;
  logic [7:0] wr_word = '0;
  logic dclk_o, data_o, data_oe, casc_n;
  logic [7:0] pat [ROWS];
  int vecs = 0, miss = 0;

  always #5 clk = ~clk;

  cfg_bit_streamer #(.ROWS(ROWS), .COLS(COLS), .HALF(HALF)) i_cfg_bit_streamer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_word(wr_word),
    .sel_n(sel_n), .oe(oe), .ext_dclk(ext_dclk), .dclk_o(dclk_o), .data_o(data_o),
    .data_oe(data_oe), .casc_n(casc_n));

  function automatic logic expbit(input int k);
    return pat[k / COLS][k % COLS];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  task automatic write_row(input int r, input logic [7:0] w);
    wr_en = 1'b1; wr_row = 4'(r); wr_word = w; pat[r] = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic oe_pulse(input logic s);
    sel_n = s; oe = 1'b0;
    repeat (2) @(negedge clk);
    oe = 1'b1;
  endtask

  task automatic stream_lead(input int first, input int n, input string req);
    int got = 0, guard = 0, last_rise = -1, cyc = 0;
    logic prev = dclk_o;
    while (got < n && guard < 100 * n + 100) begin
      @(negedge clk);
      cyc++; guard++;
      if (dclk_o && !prev) begin
        check(data_o === expbit(first + got), req, int'(data_o), int'(expbit(first + got)));
        if (last_rise >= 0 && got == 1)
          check(cyc - last_rise == 2 * HALF, "R6 period", cyc - last_rise, 2 * HALF);
        last_rise = cyc;
        got++;
      end
      prev = dclk_o;
    end
    check(got == n, "R6 clock edges", got, n);
  endtask

  task automatic t_reset();
    check(casc_n === 1'b1, "R1 casc_n", int'(casc_n), 1);
    check(data_oe === 1'b0, "R1 data_oe", int'(data_oe), 0);
    check(dclk_o === 1'b0, "R1 dclk_o", int'(dclk_o), 0);
  endtask

  task automatic t_full_stream(input string req);
    int w = 0;
    oe_pulse(1'b0);
    @(negedge clk);
    check(data_oe === 1'b1, "R4 data_oe", int'(data_oe), 1);
    check(data_o === expbit(0), "R5 first bit", int'(data_o), int'(expbit(0)));
    stream_lead(0, NBITS, req);
    while (casc_n && w < 20) begin @(negedge clk); w++; end
    check(casc_n === 1'b0, "R7 casc_n low", int'(casc_n), 0);
    check(data_oe === 1'b0, "R7 released", int'(data_oe), 0);
    sel_n = 1'b1; repeat (5) @(negedge clk);
    sel_n = 1'b0; repeat (10) @(negedge clk);
    check(casc_n === 1'b0, "R7 sticky casc_n", int'(casc_n), 0);
    check(data_oe === 1'b0 && dclk_o === 1'b0, "R7 sticky idle", int'(data_oe), 0);
  endtask

  task automatic t_oe_priority();
    oe_pulse(1'b0);
    stream_lead(0, 10, "R5 partial");
    oe = 1'b0;
    @(negedge clk);
    check(data_oe === 1'b0, "R2 data_oe", int'(data_oe), 0);
    repeat (2) @(negedge clk);
    check(dclk_o === 1'b0, "R2 dclk_o", int'(dclk_o), 0);
    check(casc_n === 1'b1, "R2 casc_n", int'(casc_n), 1);
    oe = 1'b1;
    stream_lead(0, 3, "R2 restart at bit 0");
  endtask

  task automatic t_sel_hold();
    bit quiet = 1'b1;
    oe_pulse(1'b0);
    stream_lead(0, 5, "R4 stream");
    sel_n = 1'b1;
    @(negedge clk);
    check(data_oe === 1'b0, "R3 data_oe", int'(data_oe), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dclk_o !== 1'b0) quiet = 1'b0;
    end
    check(quiet, "R3 no clock", int'(quiet), 1);
    sel_n = 1'b0;
    stream_lead(4, 4, "R3 resume at held bit");
  endtask

  task automatic t_follower();
    oe_pulse(1'b1);
    @(negedge clk);
    check(data_oe === 1'b0, "R3 deselected", int'(data_oe), 0);
    sel_n = 1'b0;
    @(negedge clk);
    check(data_oe === 1'b1 && data_o === expbit(0), "R8 bit 0", int'(data_o), int'(expbit(0)));
    for (int k = 1; k <= 3; k++) begin
      ext_dclk = 1'b1; repeat (3) @(negedge clk);
      ext_dclk = 1'b0; repeat (4) @(negedge clk);
      check(data_o === expbit(k), "R8 follower bit", int'(data_o), int'(expbit(k)));
      check(dclk_o === 1'b0, "R8 no clock", int'(dclk_o), 0);
    end
  endtask

  task automatic t_rewrite();
    oe = 1'b0;
    write_row(0, 8'hC3);
    write_row(ROWS - 1, 8'h5A);
    oe = 1'b1;
    t_full_stream("R9 rewritten data");
  endtask

  initial begin
    #(200000 * 10);
    miss++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int r = 0; r < ROWS; r++) write_row(r, 8'(8'h3C ^ (r * 29)));
    t_full_stream("R5 stream order");
    t_oe_priority();
    t_sel_hold();
    t_follower();
    t_rewrite();
    finish_run();
  end
endmodule